// File: doc/BRIEF.md
# Linear-Population Mesh Routing Switchbox

This block is the programmable junction where four routing channels of a mesh logic fabric meet. Each side (north, east, south, west) carries a bus of routing tracks. Every track index forms its own routing domain: a signal entering on track `i` can leave only on track `i` of one of the other three sides. There is one bidirectional link for each side pair and track, six per track index. Each link is set by a 2-bit field, so it can be open or can carry the signal in one chosen direction.

The configuration is loaded serially. While the shift enable is high, one bit enters per clock, and the bit that falls off the far end is presented on a serial output, so boxes can be chained. With the configuration loaded, routing is purely combinational from the input buses to the output buses. A registered flag warns when the loaded pattern makes two links fight over one output track, or makes a track index loop back on itself. The routing path has no handshake, because it models wiring and not a data stream. Control and configuration pins are plain levels.

Top module: `lin_switchbox`

## Requirements
- R1: A synchronous active-high reset clears every configuration bit to open. After reset all output buses read 0, the conflict flag reads 0 and the serial output reads 0.
- R2: While `cfg_en` is high, each clock shifts `cfg_in` into the top bit of the 12·TRACKS-bit configuration register, and all other bits move down one place. `cfg_out` always shows bit 0. After a full load, further shifts therefore emit the loaded bits in the order they were shifted in.
- R3: While `cfg_en` is low, the configuration does not change whatever `cfg_in` does, and with steady inputs the outputs stay steady.
- R4: Output track `i` of any side depends only on input track `i` of the other sides. An output track that no link drives reads 0.
- R5: Field code 01 drives from the lower-numbered side to the higher-numbered side of the pair. Sides are numbered north=0, east=1, south=2, west=3.
- R6: Field code 10 drives from the higher-numbered side to the lower-numbered side.
- R7: Field codes 00 and 11 both leave the link open.
- R8: When several links drive the same output track, that output is the OR of their source input tracks.
- R9: The conflict flag goes high one clock after the configuration first has any output track driven by more than one link. It stays high while such a configuration is held and clears one clock after it is gone.
- R10: The conflict flag, with the same one-clock latency, also goes high when the links of one track index form a directed loop over three or four sides. A chain of links that does not close does not raise it.
- R11: The field for track `t`, side pair `p` sits at configuration bits `[2·(6t+p)+1 : 2·(6t+p)]`. The pair order `p`=0..5 is (N,E), (N,S), (N,W), (E,S), (E,W), (S,W).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration input |
| cfg_out | output | 1 | Serial configuration output (bit 0 of the chain) |
| n_in | input | TRACKS | North side input tracks |
| e_in | input | TRACKS | East side input tracks |
| s_in | input | TRACKS | South side input tracks |
| w_in | input | TRACKS | West side input tracks |
| n_out | output | TRACKS | North side output tracks |
| e_out | output | TRACKS | East side output tracks |
| s_out | output | TRACKS | South side output tracks |
| w_out | output | TRACKS | West side output tracks |
| conflict | output | 1 | Registered flag for contention or loop in the loaded configuration |

## Verification
Single-link configurations with single-side stimulus show each direction code and the reserved code separately. A one-hot bit pattern placed in a high track and pair shows the field layout and that no signal crosses between track indices. Two links aimed at one output, tried with one source high and then both sources low, separate an OR from any other merge and also raise the contention flag. A closed three-side ring and the same ring with one link removed separate loop detection from a plain chain. Random dense and sparse configurations under random inputs are then compared each clock with a behavioural model that counts drivers and walks back along the predecessor links.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
  localparam int SIDES     = 4;
  localparam int PAIRS     = 6;
  localparam int FLD_W     = 2;
  localparam int TRK_CFG_W = PAIRS * FLD_W;

  typedef enum logic [1:0] {
    LINK_OFF  = 2'b00,
    LINK_UP   = 2'b01,
    LINK_DOWN = 2'b10,
    LINK_RSVD = 2'b11
  } link_e;

  // adjacency: [src][dst]
  typedef logic [SIDES-1:0][SIDES-1:0] adj_t;

  function automatic int pair_lo(input int p);
    case (p)
      0, 1, 2: return 0;
      3, 4:    return 1;
      default: return 2;
    endcase
  endfunction

  function automatic int pair_hi(input int p);
    case (p)
      0:       return 1;
      1, 3:    return 2;
      default: return 3;
    endcase
  endfunction

  // boolean matrix product: path a then b
  function automatic adj_t adj_step(input adj_t a, input adj_t b);
    adj_t r;
    r = '0;
    for (int x = 0; x < SIDES; x++)
      for (int z = 0; z < SIDES; z++)
        for (int y = 0; y < SIDES; y++)
          r[x][z] = r[x][z] | (a[x][y] & b[y][z]);
    return r;
  endfunction
endpackage

// File: rtl/sbx_cfg_chain.sv
module sbx_cfg_chain #(
  parameter int LEN = 48
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           sin,
  output logic           sout,
  output logic [LEN-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (shift_en) q <= {sin, q[LEN-1:1]};
  end

  assign sout = q[0];
endmodule

// File: rtl/sbx_track.sv
module sbx_track
  import sbx_pkg::*;
(
  input  logic [TRK_CFG_W-1:0] fld,
  input  logic [SIDES-1:0]     side_in,
  output logic [SIDES-1:0]     side_out,
  output logic                 clash
);
  adj_t  drv;
  adj_t  reach2;
  adj_t  reach4;
  logic  multi;
  logic  loop;

  always_comb begin
    drv = '0;
    for (int p = 0; p < PAIRS; p++) begin
      case (link_e'(fld[FLD_W*p +: FLD_W]))
        LINK_UP:   drv[pair_lo(p)][pair_hi(p)] = 1'b1;
        LINK_DOWN: drv[pair_hi(p)][pair_lo(p)] = 1'b1;
        default:   ;
      endcase
    end
  end

  always_comb begin
    side_out = '0;
    multi    = 1'b0;
    for (int d = 0; d < SIDES; d++) begin
      int cnt;
      cnt = 0;
      for (int s = 0; s < SIDES; s++) begin
        side_out[d] = side_out[d] | (side_in[s] & drv[s][d]);
        cnt = cnt + int'(drv[s][d]);
      end
      if (cnt > 1) multi = 1'b1;
    end
  end

  // paths of length up to four expose any closed ring over four sides
  always_comb begin
    reach2 = drv | adj_step(drv, drv);
    reach4 = reach2 | adj_step(reach2, reach2);
    loop   = 1'b0;
    for (int s = 0; s < SIDES; s++)
      loop = loop | reach4[s][s];
  end

  assign clash = multi | loop;
endmodule

// File: rtl/lin_switchbox.sv
module lin_switchbox
  import sbx_pkg::*;
#(
  parameter int TRACKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_in,
  output logic              cfg_out,
  input  logic [TRACKS-1:0] n_in,
  input  logic [TRACKS-1:0] e_in,
  input  logic [TRACKS-1:0] s_in,
  input  logic [TRACKS-1:0] w_in,
  output logic [TRACKS-1:0] n_out,
  output logic [TRACKS-1:0] e_out,
  output logic [TRACKS-1:0] s_out,
  output logic [TRACKS-1:0] w_out,
  output logic              conflict
);
  localparam int CFG_W = TRACKS * TRK_CFG_W;

  logic [CFG_W-1:0]  cfg_q;
  logic [TRACKS-1:0] clash_vec;
  logic              conflict_q;

  sbx_cfg_chain #(.LEN(CFG_W)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_en),
    .sin      (cfg_in),
    .sout     (cfg_out),
    .q        (cfg_q)
  );

  for (genvar i = 0; i < TRACKS; i++) begin : g_trk
    logic [SIDES-1:0] tin;
    logic [SIDES-1:0] tout;
    assign tin = {w_in[i], s_in[i], e_in[i], n_in[i]};

    sbx_track u_trk (
      .fld      (cfg_q[TRK_CFG_W*i +: TRK_CFG_W]),
      .side_in  (tin),
      .side_out (tout),
      .clash    (clash_vec[i])
    );

    assign n_out[i] = tout[0];
    assign e_out[i] = tout[1];
    assign s_out[i] = tout[2];
    assign w_out[i] = tout[3];
  end

  always_ff @(posedge clk) begin
    if (rst) conflict_q <= 1'b0;
    else     conflict_q <= |clash_vec;
  end

  assign conflict = conflict_q;
endmodule

// File: rtl/sbx_checker.sv
module sbx_checker #(
  parameter int TRACKS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_en,
  input logic                 cfg_out,
  input logic [TRACKS*12-1:0] cfg_q,
  input logic [TRACKS-1:0]    n_in,
  input logic [TRACKS-1:0]    e_in,
  input logic [TRACKS-1:0]    s_in,
  input logic [TRACKS-1:0]    w_in,
  input logic [TRACKS-1:0]    n_out,
  input logic [TRACKS-1:0]    e_out,
  input logic [TRACKS-1:0]    s_out,
  input logic [TRACKS-1:0]    w_out,
  input logic                 conflict
);
  logic outs_zero;
  logic ins_zero;
  assign outs_zero = (n_out == '0) && (e_out == '0) && (s_out == '0) && (w_out == '0);
  assign ins_zero  = (n_in == '0) && (e_in == '0) && (s_in == '0) && (w_in == '0);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!conflict && !cfg_out && outs_zero));

  assert_open_cfg_R1: assert property (@(posedge clk) disable iff (rst)
    (cfg_q == '0) |-> outs_zero);

  assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (cfg_out == $past(cfg_q[1])));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg_q));

  assert_no_source_R4: assert property (@(posedge clk) disable iff (rst)
    ins_zero |-> outs_zero);

  assert_clean_cfg_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_q == '0) |=> !conflict);
endmodule

bind lin_switchbox sbx_checker #(.TRACKS(TRACKS)) u_sbx_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_en   (cfg_en),
  .cfg_out  (cfg_out),
  .cfg_q    (cfg_q),
  .n_in     (n_in),
  .e_in     (e_in),
  .s_in     (s_in),
  .w_in     (w_in),
  .n_out    (n_out),
  .e_out    (e_out),
  .s_out    (s_out),
  .w_out    (w_out),
  .conflict (conflict)
);

// File: tb/tb_lin_switchbox.sv
module tb_lin_switchbox;
  localparam int TR = 4;
  localparam int CW = TR * 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b0;
  logic cfg_in = 1'b0;
  logic cfg_out;
  logic [TR-1:0] n_in = '0, e_in = '0, s_in = '0, w_in = '0;
  logic [TR-1:0] n_out, e_out, s_out, w_out;
  logic conflict;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  lin_switchbox #(.TRACKS(TR)) dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(cfg_out),
    .n_in(n_in), .e_in(e_in), .s_in(s_in), .w_in(w_in),
    .n_out(n_out), .e_out(e_out), .s_out(s_out), .w_out(w_out),
    .conflict(conflict)
  );

  // ---------------- behavioural reference ----------------
  logic [CW-1:0] shadow = '0;
  logic          exp_cf = 1'b0;

  function automatic int pidx(int a, int b);  // a < b
    if (a == 0) return b - 1;          // (0,1)=0 (0,2)=1 (0,3)=2
    else if (a == 1) return b + 1;     // (1,2)=3 (1,3)=4
    else return 5;                     // (2,3)
  endfunction

  function automatic bit drives(logic [CW-1:0] c, int t, int src, int dst);
    logic [1:0] code;
    int lo, hi;
    if (src == dst) return 0;
    lo = (src < dst) ? src : dst;
    hi = (src < dst) ? dst : src;
    code = c[2*(6*t + pidx(lo, hi)) +: 2];
    return (src < dst) ? (code == 2'b01) : (code == 2'b10);
  endfunction

  function automatic logic [TR-1:0] model_out(logic [CW-1:0] c, int dst,
      logic [TR-1:0] i0, logic [TR-1:0] i1, logic [TR-1:0] i2, logic [TR-1:0] i3);
    logic [TR-1:0] r;
    logic [3:0] bits;
    r = '0;
    for (int t = 0; t < TR; t++) begin
      bits = {i3[t], i2[t], i1[t], i0[t]};
      for (int s = 0; s < 4; s++)
        if (drives(c, t, s, dst) && bits[s]) r[t] = 1'b1;
    end
    return r;
  endfunction

  function automatic bit model_conf(logic [CW-1:0] c);
    for (int t = 0; t < TR; t++) begin
      int pred [4];
      for (int d = 0; d < 4; d++) begin
        int n;
        n = 0;
        pred[d] = -1;
        for (int s = 0; s < 4; s++)
          if (drives(c, t, s, d)) begin n++; pred[d] = s; end
        if (n > 1) return 1;
      end
      for (int s = 0; s < 4; s++) begin
        int cur;
        cur = s;
        for (int k = 0; k < 4; k++) begin
          if (cur >= 0) cur = pred[cur];
          if (cur == s) return 1;
        end
      end
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    exp_cf <= rst ? 1'b0 : model_conf(shadow);
    if (rst)         shadow <= '0;
    else if (cfg_en) shadow <= {cfg_in, shadow[CW-1:1]};
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, well away from the rising edge
  always @(negedge clk) begin
    #5;
    if (!rst && !finished) begin
      chk("R4 n_out", 32'(n_out), 32'(model_out(shadow, 0, n_in, e_in, s_in, w_in)));
      chk("R4 e_out", 32'(e_out), 32'(model_out(shadow, 1, n_in, e_in, s_in, w_in)));
      chk("R4 s_out", 32'(s_out), 32'(model_out(shadow, 2, n_in, e_in, s_in, w_in)));
      chk("R4 w_out", 32'(w_out), 32'(model_out(shadow, 3, n_in, e_in, s_in, w_in)));
      chk("R9 conflict", 32'(conflict), 32'(exp_cf));
      chk("R2 cfg_out", 32'(cfg_out), 32'(shadow[0]));
    end
  end

  task automatic load(logic [CW-1:0] v);
    for (int k = 0; k < CW; k++) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_in = v[k];
    end
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_in = 1'b0;
  endtask

  task automatic drive_in(logic [TR-1:0] n, logic [TR-1:0] e, logic [TR-1:0] s, logic [TR-1:0] w);
    n_in = n; e_in = e; s_in = s; w_in = w;
    #2;
  endtask

  task automatic settle2;
    @(negedge clk);
    @(negedge clk);
    #2;
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] v;
    logic [TR-1:0] hold_n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    drive_in('1, '1, '1, '1);
    chk("R1 outs after reset", 32'({n_out, e_out, s_out, w_out}), 32'h0);
    chk("R1 conflict after reset", 32'(conflict), 32'h0);
    chk("R1 cfg_out after reset", 32'(cfg_out), 32'h0);

    // R5: pair (N,E) code 01 on track 0
    drive_in('0, '0, '0, '0);
    load(48'h1);
    drive_in(4'b0001, '0, '0, '0);
    chk("R5 e_out from north", 32'(e_out), 32'h1);
    chk("R5 n_out idle", 32'(n_out), 32'h0);

    // R6: pair (N,E) code 10
    load(48'h2);
    drive_in('0, 4'b0001, '0, '0);
    chk("R6 n_out from east", 32'(n_out), 32'h1);
    drive_in(4'b0001, '0, '0, '0);
    chk("R6 no forward path", 32'(e_out), 32'h0);

    // R7: reserved code 11 is open
    load(48'h3);
    drive_in('1, '1, '1, '1);
    chk("R7 code 11 open", 32'({n_out, e_out, s_out, w_out}), 32'h0);

    // R11 / R4: track 2, pair (S,W) code 01 at bits 35:34
    v = '0; v[34] = 1'b1;
    load(v);
    drive_in('1, '1, 4'b1111, '1);
    chk("R11 w_out track2 only", 32'(w_out), 32'h4);
    chk("R4 other sides idle", 32'({n_out, e_out, s_out}), 32'h0);

    // R8 / R9: track1 N->E and S->E
    v = '0; v[13:12] = 2'b01; v[19:18] = 2'b10;
    load(v);
    drive_in(4'b0010, '0, '0, '0);
    chk("R8 OR one source", 32'(e_out), 32'h2);
    drive_in('0, '0, 4'b0010, '0);
    chk("R8 OR other source", 32'(e_out), 32'h2);
    drive_in('0, '0, '0, '0);
    chk("R8 OR both low", 32'(e_out), 32'h0);
    settle2;
    chk("R9 two drivers flagged", 32'(conflict), 32'h1);

    // R10: ring on track 3: N->E, E->S, S->N
    v = '0; v[37:36] = 2'b01; v[43:42] = 2'b01; v[39:38] = 2'b10;
    load(v);
    settle2;
    chk("R10 ring flagged", 32'(conflict), 32'h1);
    v[39:38] = 2'b00;
    load(v);
    settle2;
    chk("R10 open chain not flagged", 32'(conflict), 32'h0);
    drive_in(4'b1000, '0, '0, '0);
    chk("R10 chain middle", 32'(e_out), 32'h8);

    // R3: hold with noise on cfg_in
    hold_n = n_out;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cfg_in = k[0];
    end
    #2;
    chk("R3 held outputs", 32'({n_out, e_out}), 32'({hold_n, 4'b1000}));
    chk("R3 held cfg_out", 32'(cfg_out), 32'(v[0]));

    // R2: unload bits in order
    v = 48'hA5C3_1E96_0F3B;
    load(v);
    for (int k = 0; k < CW; k++) begin
      @(negedge clk); #2;
      chk("R2 chain order", 32'(cfg_out), 32'(v[k]));
      cfg_en = 1'b1;
      cfg_in = 1'b0;
    end
    @(negedge clk);
    cfg_en = 1'b0;

    // random dense and sparse configurations
    for (int r = 0; r < 40; r++) begin
      v = {$urandom, $urandom};
      if (r[0]) v = v & {$urandom, $urandom} & {$urandom, $urandom};
      load(v);
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        drive_in(TR'($urandom), TR'($urandom), TR'($urandom), TR'($urandom));
      end
    end

    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule